// File: doc/BRIEF.md
# Sleep Entry Controller

This block governs the low-power sleep state of a synchronous SRAM model. An active-high sleep request arrives asynchronously to the clock. The block passes it through a synchronizer, then walks a fixed entry window before sleep takes effect. On release it walks a fixed recovery window before normal accesses are allowed again. From the moment entry starts until recovery ends, it blocks every access and keeps the data drivers off. Any access still pending when entry starts is therefore discarded, and the array contents are left untouched.

Sleep takes priority over every other control. The sequence advances on every clock edge and has no enable input that could stall it. Two protocol checks are built in. Entering sleep while the core reports the device as selected raises an entry-error pulse. A chip-enable selection that arrives inside the recovery window raises a recovery-error pulse, and that access stays blocked.

Top module: `sleep_entry_ctrl`

## Requirements
- R1: While `rstN` is low and after it is released with `sleepReq` low, all five outputs are 0.
- R2: After `sleepReq` rises, `accessBlock` and `outputDisable` become 1 after SYNC_STAGES+1 rising clock edges. `sleepActive` becomes 1 ENTRY_CYCLES edges after that.
- R3: While `sleepActive` is 1, `accessBlock` and `outputDisable` are both 1.
- R4: After `sleepReq` falls from the sleep state, `sleepActive` becomes 0 after SYNC_STAGES+1 edges. `accessBlock` and `outputDisable` stay 1 for EXIT_CYCLES more edges and then return to 0.
- R5: If the synchronized request drops before the entry window completes, the block returns to the awake state on the next edge. `sleepActive` never rises.
- R6: If the synchronized request reappears during the recovery window, `sleepActive` returns to 1 on the next edge. No new entry window is walked.
- R7: If `coreSelected` is 1 on the edge where entry starts, `entryErr` is 1 for exactly the following clock cycle, together with `accessBlock`.
- R8: A `selAttempt` of 1 on an edge inside the recovery window makes `recoveryErr` 1 for the following cycle. That access stays blocked because `accessBlock` is still 1 at that edge.
- R9: `selAttempt` outside the recovery window never raises `recoveryErr`. `coreSelected` without a sleep request never raises `entryErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepReq | input | 1 | Sleep request, active high, asynchronous |
| coreSelected | input | 1 | 1 while the core reports the device selected |
| selAttempt | input | 1 | 1 when all chip enables select the device on this edge |
| sleepActive | output | 1 | 1 while sleep is in effect |
| accessBlock | output | 1 | 1 while accesses must be discarded |
| outputDisable | output | 1 | 1 while the data drivers must stay off |
| entryErr | output | 1 | One-cycle pulse: entry started while selected |
| recoveryErr | output | 1 | One-cycle pulse: selection arrived during recovery |

## Verification
A selection that arrives on the last edge of the recovery window falls in the same cycle as the release of the access block. The bench provokes this by releasing the request, counting edges to the final recovery cycle, and raising `selAttempt` there. It judges the result by requiring `recoveryErr` to pulse while `accessBlock` still reads 1 at that point, with both low one edge later. A second overlap, a request reasserted inside recovery, is judged by `sleepActive` returning on the very next edge instead of after a fresh entry window.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ENTER   = 2'd1,
    ST_ASLEEP  = 2'd2,
    ST_RECOVER = 2'd3
  } sleepState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadEntry;
    logic loadExit;
    logic countDown;
    logic flagEntry;
    logic flagRecover;
  } sleepStrobe_t;

endpackage

// File: rtl/sleep_req_datapath.sv
module sleep_req_datapath
  import sleep_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sleepReq,
  input  sleepStrobe_t strobe,
  output logic         reqSync,
  output logic         cntZero,
  output logic         entryErr,
  output logic         recoveryErr
);

  localparam int MAX_CYC = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       winCnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= sleepReq;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], sleepReq};
      end
    end
  endgenerate

  assign reqSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (strobe.loadEntry) begin
      winCnt <= ENTRY_LOAD;
    end else if (strobe.loadExit) begin
      winCnt <= EXIT_LOAD;
    end else if (strobe.countDown && (winCnt != '0)) begin
      winCnt <= winCnt - 1'b1;
    end
  end

  assign cntZero = (winCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryErr    <= 1'b0;
      recoveryErr <= 1'b0;
    end else begin
      entryErr    <= strobe.flagEntry;
      recoveryErr <= strobe.flagRecover;
    end
  end

endmodule

// File: rtl/sleep_seq_control.sv
module sleep_seq_control
  import sleep_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqSync,
  input  logic         cntZero,
  input  logic         coreSelected,
  input  logic         selAttempt,
  output sleepStrobe_t strobe,
  output logic         sleepActive,
  output logic         accessBlock,
  output logic         outputDisable
);

  sleepState_t curState, nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_AWAKE;
    else       curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    strobe   = '0;
    unique case (curState)
      ST_AWAKE: begin
        if (reqSync) begin
          nxtState         = ST_ENTER;
          strobe.loadEntry = 1'b1;
          strobe.flagEntry = coreSelected;
        end
      end
      ST_ENTER: begin
        if (!reqSync) begin
          nxtState = ST_AWAKE;
        end else if (cntZero) begin
          nxtState = ST_ASLEEP;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      ST_ASLEEP: begin
        if (!reqSync) begin
          nxtState        = ST_RECOVER;
          strobe.loadExit = 1'b1;
        end
      end
      ST_RECOVER: begin
        strobe.flagRecover = selAttempt;
        if (reqSync) begin
          nxtState = ST_ASLEEP;
        end else if (cntZero) begin
          nxtState = ST_AWAKE;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      default: nxtState = ST_AWAKE;
    endcase
  end

  assign sleepActive   = (curState == ST_ASLEEP);
  assign accessBlock   = (curState != ST_AWAKE);
  assign outputDisable = (curState != ST_AWAKE);

endmodule

// File: rtl/sleep_entry_ctrl.sv
module sleep_entry_ctrl
  import sleep_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic coreSelected,
  input  logic selAttempt,
  output logic sleepActive,
  output logic accessBlock,
  output logic outputDisable,
  output logic entryErr,
  output logic recoveryErr
);

  sleepStrobe_t strobe;
  logic         reqSync;
  logic         cntZero;

  sleep_req_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .ENTRY_CYCLES(ENTRY_CYCLES),
    .EXIT_CYCLES (EXIT_CYCLES)
  ) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .sleepReq   (sleepReq),
    .strobe     (strobe),
    .reqSync    (reqSync),
    .cntZero    (cntZero),
    .entryErr   (entryErr),
    .recoveryErr(recoveryErr)
  );

  sleep_seq_control control_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqSync      (reqSync),
    .cntZero      (cntZero),
    .coreSelected (coreSelected),
    .selAttempt   (selAttempt),
    .strobe       (strobe),
    .sleepActive  (sleepActive),
    .accessBlock  (accessBlock),
    .outputDisable(outputDisable)
  );

endmodule

module sleep_entry_ctrl_checker (
  input logic clk,
  input logic rstN,
  input logic sleepActive,
  input logic accessBlock,
  input logic outputDisable,
  input logic entryErr,
  input logic recoveryErr
);

  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    sleepActive |-> (accessBlock && outputDisable)); // R3

  AST_SLEEP_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepActive) |-> $past(accessBlock)); // R2

  AST_WAKE_VIA_RECOVERY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accessBlock) |-> !$past(sleepActive)); // R4

  AST_ENTRY_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    entryErr |=> !entryErr); // R7

  AST_ENTRY_ERR_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    entryErr |-> accessBlock); // R7

  AST_RECOVERY_ERR_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    recoveryErr |-> ($past(accessBlock) && !$past(sleepActive))); // R8

  AST_NO_RECOVERY_ERR_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(accessBlock) |-> !recoveryErr); // R9

endmodule

bind sleep_entry_ctrl sleep_entry_ctrl_checker checker_i (
  .clk          (clk),
  .rstN         (rstN),
  .sleepActive  (sleepActive),
  .accessBlock  (accessBlock),
  .outputDisable(outputDisable),
  .entryErr     (entryErr),
  .recoveryErr  (recoveryErr)
);

// File: tb/sleep_entry_ctrl_tb.sv
`timescale 1ns/100ps
module sleep_entry_ctrl_tb_top;

  localparam int SYNC_STAGES  = 2;
  localparam int ENTRY_CYCLES = 2;
  localparam int EXIT_CYCLES  = 2;
  localparam int LAT          = SYNC_STAGES + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0;
  logic coreSelected = 1'b0;
  logic selAttempt = 1'b0;
  logic sleepActive, accessBlock, outputDisable, entryErr, recoveryErr;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  finished   = 1'b0;

  always #2.5 clk = ~clk;

  sleep_entry_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .ENTRY_CYCLES(ENTRY_CYCLES),
    .EXIT_CYCLES (EXIT_CYCLES)
  ) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .sleepReq     (sleepReq),
    .coreSelected (coreSelected),
    .selAttempt   (selAttempt),
    .sleepActive  (sleepActive),
    .accessBlock  (accessBlock),
    .outputDisable(outputDisable),
    .entryErr     (entryErr),
    .recoveryErr  (recoveryErr)
  );

  task automatic checkBit(input string tag, input logic actual, input logic expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s: actual %0b expected %0b", tag, actual, expected);
    end
  endtask

  // advance n rising edges, then settle at the falling edge
  task automatic stepTo(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic goToSleep();
    sleepReq = 1'b1;
    stepTo(LAT + ENTRY_CYCLES);
  endtask

  task automatic wakeUp();
    sleepReq = 1'b0;
    stepTo(LAT + EXIT_CYCLES);
  endtask

  task automatic testReset();
    checkBit("R1 sleepActive in reset", sleepActive, 1'b0);
    checkBit("R1 accessBlock in reset", accessBlock, 1'b0);
    rstN = 1'b1;
    stepTo(3);
    checkBit("R1 sleepActive after reset", sleepActive, 1'b0);
    checkBit("R1 accessBlock after reset", accessBlock, 1'b0);
    checkBit("R1 outputDisable after reset", outputDisable, 1'b0);
    checkBit("R1 entryErr after reset", entryErr, 1'b0);
    checkBit("R1 recoveryErr after reset", recoveryErr, 1'b0);
  endtask

  task automatic testEntryExit();
    sleepReq = 1'b1;
    stepTo(LAT - 1);
    checkBit("R2 block not yet", accessBlock, 1'b0);
    stepTo(1);
    checkBit("R2 block rises", accessBlock, 1'b1);
    checkBit("R2 outputs off", outputDisable, 1'b1);
    checkBit("R2 not asleep yet", sleepActive, 1'b0);
    stepTo(ENTRY_CYCLES - 1);
    checkBit("R2 entry window", sleepActive, 1'b0);
    stepTo(1);
    checkBit("R2 sleep effective", sleepActive, 1'b1);
    stepTo(4);
    checkBit("R3 sleep held", sleepActive, 1'b1);
    checkBit("R3 block held", accessBlock, 1'b1);
    checkBit("R3 outputs off held", outputDisable, 1'b1);
    sleepReq = 1'b0;
    stepTo(LAT - 1);
    checkBit("R4 still asleep", sleepActive, 1'b0 ^ 1'b1);
    stepTo(1);
    checkBit("R4 sleep ends", sleepActive, 1'b0);
    checkBit("R4 block in recovery", accessBlock, 1'b1);
    stepTo(EXIT_CYCLES - 1);
    checkBit("R4 outputs off in recovery", outputDisable, 1'b1);
    stepTo(1);
    checkBit("R4 block released", accessBlock, 1'b0);
    checkBit("R4 outputs released", outputDisable, 1'b0);
  endtask

  task automatic testAbort();
    sleepReq = 1'b1;
    stepTo(1);
    sleepReq = 1'b0;
    stepTo(2);
    checkBit("R5 entry started", accessBlock, 1'b1);
    stepTo(1);
    checkBit("R5 aborted to awake", accessBlock, 1'b0);
    stepTo(3);
    checkBit("R5 no sleep", sleepActive, 1'b0);
  endtask

  task automatic testResleep();
    goToSleep();
    sleepReq = 1'b0;
    stepTo(1);
    sleepReq = 1'b1;
    stepTo(2);
    checkBit("R6 in recovery", sleepActive, 1'b0);
    checkBit("R6 blocked in recovery", accessBlock, 1'b1);
    stepTo(1);
    checkBit("R6 direct return to sleep", sleepActive, 1'b1);
    wakeUp();
    checkBit("R6 awake again", accessBlock, 1'b0);
  endtask

  task automatic testEntryError();
    coreSelected = 1'b1;
    stepTo(4);
    checkBit("R9 selected without request", entryErr, 1'b0);
    sleepReq = 1'b1;
    stepTo(LAT);
    checkBit("R7 entryErr raised", entryErr, 1'b1);
    checkBit("R7 block with error", accessBlock, 1'b1);
    stepTo(1);
    checkBit("R7 entryErr one cycle", entryErr, 1'b0);
    coreSelected = 1'b0;
    stepTo(ENTRY_CYCLES);
    checkBit("R7 sleep still entered", sleepActive, 1'b1);
    wakeUp();
  endtask

  task automatic testRecoveryError();
    selAttempt = 1'b1;
    stepTo(2);
    checkBit("R9 selection while awake", recoveryErr, 1'b0);
    selAttempt = 1'b0;
    goToSleep();
    selAttempt = 1'b1;
    stepTo(1);
    checkBit("R9 selection while asleep", recoveryErr, 1'b0);
    selAttempt = 1'b0;
    sleepReq = 1'b0;
    stepTo(LAT + EXIT_CYCLES - 2);
    selAttempt = 1'b1;
    stepTo(1);
    checkBit("R8 recoveryErr raised", recoveryErr, 1'b1);
    checkBit("R8 access still blocked", accessBlock, 1'b1);
    selAttempt = 1'b0;
    stepTo(1);
    checkBit("R8 recoveryErr one cycle", recoveryErr, 1'b0);
    checkBit("R8 block released after window", accessBlock, 1'b0);
  endtask

  initial begin
    stepTo(3);
    testReset();
    testEntryExit();
    testAbort();
    testResleep();
    testEntryError();
    testRecoveryError();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired (all requirements): actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule